// File: doc/BRIEF.md
# BCD Decimal Adjust Accumulator Unit

This block is an 8-bit accumulator with a small arithmetic datapath. It offers binary add, add-with-carry, subtract and subtract-with-borrow, and a decimal-adjust step. When two packed-BCD bytes are combined in binary and the adjust step follows, the accumulator holds the correct two-digit BCD result and the carry flag shows a decimal carry or borrow.

The adjust step does not look at the digits alone. It uses the subtract, half-carry and carry flags that the previous arithmetic operation left behind. From these it picks a correction of 0x00, 0x06, 0x60 or 0x66. That correction is added after an addition and taken away after a subtraction.

Every operation is accepted on a clock edge where `start` is high and finishes in that one edge. The flag register keeps its value from one operation to the next, so a sequence such as add, then adjust, works without outside help.

Top module: `bcd_accum_unit`

## Requirements
- R1: A synchronous active-low reset clears the accumulator to 0x00 and all six flag bits to 0. The flag bit positions are: bit 5 sign, bit 4 zero, bit 3 half-carry, bit 2 parity/overflow, bit 1 subtract, bit 0 carry.
- R2: Operation codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow and 4 adjust. An operation takes effect at a rising edge where `start` is 1. When `start` is 0, or when the code is 5, 6 or 7, the accumulator and the flags stay unchanged.
- R3: Add and add-with-carry store (acc + operand [+ C]) mod 256. They set C to the carry out of bit 7 and H to the carry out of bit 3. They set parity/overflow to the two's-complement overflow, and they clear N.
- R4: Subtract and subtract-with-borrow store (acc − operand [− C]) mod 256. They set C to the borrow out of bit 7 and H to the borrow out of bit 3. They set parity/overflow to the two's-complement overflow, and they set N.
- R5: Adjust selects a low correction of 0x06 when H=1 or the low nibble is above 9. It selects a high correction of 0x60 when C=1 or the accumulator is above 0x99. The summed correction is added when N=0 and subtracted when N=1, for every input combination.
- R6: After adjust, C is 1 exactly when the high correction was selected. N keeps its previous value.
- R7: After adjust, H is the carry (N=0) or the borrow (N=1) out of bit 3 that the correction causes.
- R8: After every operation, sign equals bit 7 of the new accumulator and zero is set exactly when the new accumulator is 0x00. After adjust, parity/overflow is 1 when the result has an even number of one bits.
- R9: For every pair of BCD values a, b in 00..99, loading a and then adding b and adjusting gives (a+b) mod 100 in BCD, with C = (a+b ≥ 100). Loading a and then subtracting b and adjusting gives (a−b) mod 100 in BCD, with C = (a < b).
- R10: Adding 0x27 to 0x15 gives 0x3C. The adjust that follows gives 0x42 with H=1 and C=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Perform the selected operation at this edge |
| op | input | 3 | Operation code (see R2) |
| operand | input | 8 | Second operand for add and subtract |
| acc | output | 8 | Accumulator |
| flags | output | 6 | Flag register {S, Z, H, PV, N, C} |

## Verification
The adjust step is driven three ways. The first is the full cross-product of valid BCD operands, both after addition and after subtraction; this separates the carry-in and borrow-in paths and the four correction values. The second is a set of flag states outside the table, such as 0xFF or a lone half-carry, which shows that selection follows the flag-or-range rule and not a lookup of listed rows. The third runs carry-chained add-with-carry and subtract-with-borrow steps, signed-overflow operands, and idle or unused codes; these separate the binary flag updates and the hold behaviour from the correction logic.

// File: rtl/bcd_accum_pkg.sv
// Package: shared widths, operation codes and flag layout for the BCD accumulator.
// Assumes: the accumulator holds exactly two BCD digits.
package bcd_accum_pkg;
    localparam int DIGIT_W = 4;
    localparam int DIGITS  = 2;
    localparam int DATA_W  = DIGIT_W * DIGITS;
    localparam int OP_W    = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_ADJ = 3'd4
    } op_e;

    // Flag register, bit 5 down to bit 0.
    typedef struct packed {
        logic s;
        logic z;
        logic h;
        logic pv;
        logic n;
        logic c;
    } flags_t;

    localparam int FLAG_W = $bits(flags_t);
endpackage

// File: rtl/bcd_bin_alu.sv
// Module: binary add/subtract with optional carry-in.
// It produces the result, the carry/borrow out of the top bit and out of the low
// nibble, and the signed overflow. Assumes: sub=1 means a - b - cin.
module bcd_bin_alu
    import bcd_accum_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              use_cin,
    input  logic              sub,
    output logic [DATA_W-1:0] res,
    output logic              c_out,
    output logic              h_out,
    output logic              v_out
);
    logic              cin_eff;
    logic [DATA_W:0]   full;
    logic [DIGIT_W:0]  low;
    logic [DATA_W:0]   cin_full;
    logic [DIGIT_W:0]  cin_low;

    assign cin_eff  = use_cin & cin;
    assign cin_full = {{DATA_W{1'b0}}, cin_eff};
    assign cin_low  = {{DIGIT_W{1'b0}}, cin_eff};

    // Purpose: full-width and low-nibble arithmetic; the extra top bit is carry or borrow.
    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b} - cin_full;
            low  = {1'b0, a[DIGIT_W-1:0]} - {1'b0, b[DIGIT_W-1:0]} - cin_low;
        end else begin
            full = {1'b0, a} + {1'b0, b} + cin_full;
            low  = {1'b0, a[DIGIT_W-1:0]} + {1'b0, b[DIGIT_W-1:0]} + cin_low;
        end
    end

    assign res   = full[DATA_W-1:0];
    assign c_out = full[DATA_W];
    assign h_out = low[DIGIT_W];

    // Purpose: signed overflow from the operand and result sign bits.
    always_comb begin
        if (sub)
            v_out = (a[DATA_W-1] ^ b[DATA_W-1]) & (res[DATA_W-1] ^ a[DATA_W-1]);
        else
            v_out = ~(a[DATA_W-1] ^ b[DATA_W-1]) & (res[DATA_W-1] ^ a[DATA_W-1]);
    end
endmodule

// File: rtl/bcd_adjust.sv
// Module: decimal correction of the accumulator.
// It picks a per-digit correction of 6 from the flags and the digit ranges, then adds
// it (after an add) or subtracts it (after a subtract).
// Assumes: two digits; the flags come from the previous arithmetic operation.
module bcd_adjust
    import bcd_accum_pkg::*;
(
    input  logic [DATA_W-1:0] acc_in,
    input  logic              n_in,
    input  logic              h_in,
    input  logic              c_in,
    output logic [DATA_W-1:0] res,
    output logic              c_out,
    output logic              h_out
);
    localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;
    localparam logic [DIGIT_W-1:0] FIX       = 4'd6;
    localparam logic [DATA_W-1:0]  BYTE_MAX  = 8'h99;

    logic [DIGITS-1:0]       fix_en;
    logic [DATA_W-1:0]       corr;
    logic [DIGIT_W:0]        low_sum;

    // Purpose: low-digit fix when half-carry is set or the digit is out of range.
    assign fix_en[0] = h_in | (acc_in[DIGIT_W-1:0] > DIGIT_MAX);
    // Purpose: high-digit fix when carry is set or the byte is beyond 99.
    assign fix_en[1] = c_in | (acc_in > BYTE_MAX);

    // One correction nibble for each digit.
    for (genvar g = 0; g < DIGITS; g++) begin : g_corr
        assign corr[g*DIGIT_W +: DIGIT_W] = fix_en[g] ? FIX : '0;
    end

    // Purpose: apply the correction in the direction set by the subtract flag.
    always_comb begin
        if (n_in) begin
            res     = acc_in - corr;
            low_sum = {1'b0, acc_in[DIGIT_W-1:0]} - {1'b0, corr[DIGIT_W-1:0]};
        end else begin
            res     = acc_in + corr;
            low_sum = {1'b0, acc_in[DIGIT_W-1:0]} + {1'b0, corr[DIGIT_W-1:0]};
        end
    end

    assign h_out = low_sum[DIGIT_W];
    assign c_out = fix_en[1];
endmodule

// File: rtl/bcd_accum_unit.sv
// Module: top of the BCD accumulator. It registers the accumulator and flags and
// picks the next state from the binary ALU or the decimal adjuster.
// Assumes: at most one operation per clock, qualified by start.
module bcd_accum_unit
    import bcd_accum_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] acc,
    output logic [FLAG_W-1:0] flags
);
    logic [DATA_W-1:0] acc_q, acc_d;
    flags_t            fl_q, fl_d;

    logic              is_sub, is_cin;
    logic [DATA_W-1:0] alu_res, adj_res;
    logic              alu_c, alu_h, alu_v, adj_c, adj_h;

    assign is_sub = (op == OP_SUB) || (op == OP_SBB);
    assign is_cin = (op == OP_ADC) || (op == OP_SBB);

    bcd_bin_alu u_alu (
        .a       (acc_q),
        .b       (operand),
        .cin     (fl_q.c),
        .use_cin (is_cin),
        .sub     (is_sub),
        .res     (alu_res),
        .c_out   (alu_c),
        .h_out   (alu_h),
        .v_out   (alu_v)
    );

    bcd_adjust u_adj (
        .acc_in (acc_q),
        .n_in   (fl_q.n),
        .h_in   (fl_q.h),
        .c_in   (fl_q.c),
        .res    (adj_res),
        .c_out  (adj_c),
        .h_out  (adj_h)
    );

    // Purpose: pick the next accumulator and flags for the requested operation.
    always_comb begin
        acc_d = acc_q;
        fl_d  = fl_q;
        if (start) begin
            case (op)
                OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                    acc_d   = alu_res;
                    fl_d.s  = alu_res[DATA_W-1];
                    fl_d.z  = (alu_res == '0);
                    fl_d.h  = alu_h;
                    fl_d.pv = alu_v;
                    fl_d.n  = is_sub;
                    fl_d.c  = alu_c;
                end
                OP_ADJ: begin
                    acc_d   = adj_res;
                    fl_d.s  = adj_res[DATA_W-1];
                    fl_d.z  = (adj_res == '0);
                    fl_d.h  = adj_h;
                    fl_d.pv = ~^adj_res;
                    fl_d.c  = adj_c;
                end
                default: ;
            endcase
        end
    end

    // Purpose: state registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            fl_q  <= '0;
        end else begin
            acc_q <= acc_d;
            fl_q  <= fl_d;
        end
    end

    assign acc   = acc_q;
    assign flags = fl_q;
endmodule

// File: rtl/bcd_accum_checker.sv
// Module: temporal checks on the accumulator unit's ports, bound to the top.
// Assumes: flag layout {S, Z, H, PV, N, C} from bit 5 down to bit 0.
module bcd_accum_checker
    import bcd_accum_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [OP_W-1:0]   op,
    input logic [DATA_W-1:0] acc,
    input logic [FLAG_W-1:0] flags
);
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (acc == '0 && flags == '0)); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!start || op > OP_ADJ) |=> ($stable(acc) && $stable(flags))); // R2
    AST_ADD_CLEARS_N: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (op == OP_ADD || op == OP_ADC)) |=> !flags[1]); // R3
    AST_SUB_SETS_N: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (op == OP_SUB || op == OP_SBB)) |=> flags[1]); // R4
    AST_ADJ_KEEPS_N: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == OP_ADJ) |=> $stable(flags[1])); // R6
    AST_ADJ_CARRY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == OP_ADJ && flags[0]) |=> flags[0]); // R6
    AST_ADJ_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == OP_ADJ) |=> (flags[2] == ~^acc)); // R8
    AST_ZERO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op <= OP_ADJ) |=> (flags[4] == (acc == '0) && flags[5] == acc[7])); // R8
endmodule

bind bcd_accum_unit bcd_accum_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .op    (op),
    .acc   (acc),
    .flags (flags)
);

// File: tb/bcd_accum_unit_test.sv
`timescale 1ns/1ps
module bcd_accum_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] op = 3'd0;
    logic [7:0] operand = 8'd0;
    logic [7:0] acc;
    logic [5:0] flags;

    int checks = 0;
    int errors = 0;

    // Reference state
    int m_acc = 0;
    int m_s = 0, m_z = 0, m_h = 0, m_pv = 0, m_n = 0, m_c = 0;

    always #2 clk = ~clk;

    bcd_accum_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .operand(operand), .acc(acc), .flags(flags)
    );

    function automatic int ones(int v);
        int k = 0;
        for (int i = 0; i < 8; i++) if ((v >> i) & 1) k++;
        return k;
    endfunction

    function automatic int to_bcd(int v);
        return (v / 10) * 16 + (v % 10);
    endfunction

    function automatic logic [5:0] m_flags();
        return {m_s[0], m_z[0], m_h[0], m_pv[0], m_n[0], m_c[0]};
    endfunction

    // Behavioural model of one accepted operation.
    task automatic model_apply(input int code, input int opd);
        int r, cin, sa, sb, sr, lo, corr;
        cin = (code == 1 || code == 3) ? m_c : 0;
        sa = (m_acc > 127) ? m_acc - 256 : m_acc;
        sb = (opd > 127) ? opd - 256 : opd;
        if (code == 0 || code == 1) begin
            r = m_acc + opd + cin;
            m_c = (r > 255);
            m_h = ((m_acc % 16) + (opd % 16) + cin > 15);
            sr = sa + sb + cin;
            m_pv = (sr > 127 || sr < -128);
            m_n = 0;
        end else if (code == 2 || code == 3) begin
            r = m_acc - opd - cin;
            m_c = (r < 0);
            m_h = ((m_acc % 16) < (opd % 16) + cin);
            sr = sa - sb - cin;
            m_pv = (sr > 127 || sr < -128);
            m_n = 1;
        end else if (code == 4) begin
            lo = (m_h || (m_acc % 16) > 9) ? 6 : 0;
            corr = lo + ((m_c || m_acc > 153) ? 96 : 0);
            m_c = (m_c || m_acc > 153);
            if (m_n) begin
                r = m_acc - corr;
                m_h = ((m_acc % 16) < lo);
            end else begin
                r = m_acc + corr;
                m_h = ((m_acc % 16) + lo > 15);
            end
        end else begin
            return;
        end
        m_acc = ((r % 256) + 256) % 256;
        m_s = (m_acc > 127);
        m_z = (m_acc == 0);
        if (code == 4) m_pv = (ones(m_acc) % 2 == 0);
    endtask

    task automatic check_state(input string tag);
        checks++;
        if (acc !== m_acc[7:0] || flags !== m_flags()) begin
            errors++;
            $display("FAIL %s: acc=%h flags=%b expected acc=%h flags=%b",
                     tag, acc, flags, m_acc[7:0], m_flags());
        end
    endtask

    task automatic check_val(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Called at a falling edge: drive, let one rising edge pass, compare at the next falling edge.
    task automatic step(input int code, input int opd, input bit st, input string tag);
        op = code[2:0];
        operand = opd[7:0];
        start = st;
        if (st) model_apply(code, opd);
        @(negedge clk);
        check_state(tag);
    endtask

    task automatic do_reset(input string tag);
        rst_n = 1'b0;
        start = 1'b1;
        op = 3'd0;
        operand = 8'h55;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        start = 1'b0;
        m_acc = 0; m_s = 0; m_z = 0; m_h = 0; m_pv = 0; m_n = 0; m_c = 0;
        check_state(tag);
    endtask

    task automatic load(input int v);
        step(2, m_acc, 1'b1, "R4 clear");
        step(0, v, 1'b1, "R3 load");
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin : main
        @(negedge clk);
        do_reset("R1 reset state");

        // R10 worked example
        step(0, 'h15, 1'b1, "R3 add");
        step(0, 'h27, 1'b1, "R10 add");
        check_val("R10 binary sum", acc, 'h3C);
        step(4, 0, 1'b1, "R10 R5 R7 adjust");
        check_val("R10 adjusted", acc, 'h42);
        check_val("R10 flags H/C", {flags[3], flags[0]}, 2'b10);

        // R2 idle and unused codes
        step(0, 'h55, 1'b0, "R2 start low");
        step(5, 'h11, 1'b1, "R2 code 5");
        step(6, 'h22, 1'b1, "R2 code 6");
        step(7, 'h33, 1'b1, "R2 code 7");
        check_val("R2 held acc", acc, 'h42);

        // R3 carry chain and overflow
        load('hF0);
        step(0, 'h20, 1'b1, "R3 carry out");
        step(1, 'h01, 1'b1, "R3 add with carry");
        check_val("R3 adc result", acc, 'h12);
        load('h7F);
        step(0, 'h01, 1'b1, "R3 overflow");
        check_val("R3 overflow flag", flags[2], 1);

        // R4 borrow chain and overflow
        load('h12);
        step(2, 'h20, 1'b1, "R4 borrow out");
        step(3, 'h01, 1'b1, "R4 subtract with borrow");
        check_val("R4 sbb result", acc, 'hF0);
        load('h80);
        step(2, 'h01, 1'b1, "R4 overflow");

        // R5 R6 R7 outside-table inputs and subtract corrections
        load('hFF);
        step(4, 0, 1'b1, "R5 R6 R7 adjust of FF");
        check_val("R5 FF corrected", acc, 'h65);
        load('h10);
        step(2, 'h01, 1'b1, "R4 half borrow");
        step(4, 0, 1'b1, "R5 R7 subtract low fix");
        check_val("R5 low fix after sub", acc, 'h09);
        load('h50);
        step(0, 'h50, 1'b1, "R3 high digit over");
        step(4, 0, 1'b1, "R6 R8 zero with carry");
        check_val("R8 zero flag", flags[4], 1);
        check_val("R6 carry set", flags[0], 1);
        step(4, 0, 1'b1, "R6 repeated adjust keeps N and C");
        load('h05);
        step(2, 'h06, 1'b1, "R4 wrap");
        step(4, 0, 1'b1, "R5 R6 R7 R8 subtract both fixes");
        check_val("R5 99 result", acc, 'h99);

        // R9 exhaustive BCD pairs
        for (int a = 0; a < 100; a++) begin
            for (int b = 0; b < 100; b++) begin
                load(to_bcd(a));
                step(0, to_bcd(b), 1'b1, "R9 add");
                step(4, 0, 1'b1, "R9 R5 adjust add");
                check_val("R9 add decimal", {acc, flags[0]},
                          {to_bcd((a + b) % 100), (a + b >= 100)} & 9'h1FF);
                load(to_bcd(a));
                step(2, to_bcd(b), 1'b1, "R9 sub");
                step(4, 0, 1'b1, "R9 R5 adjust sub");
                check_val("R9 sub decimal", {acc, flags[0]},
                          {to_bcd((a - b + 100) % 100), (a < b)} & 9'h1FF);
            end
        end

        // R1 reset after activity
        do_reset("R1 reset mid-run");

        summary();
        $finish;
    end
endmodule